// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block is the device-side front end of a flash memory that shares one 8-bit bus for commands, addresses and data. The bus is sampled synchronously. A one-cycle `wr_stb` marks each rising edge of the bus write-enable. When chip-enable is low, the byte on `io_in` is classified by the two latch-enable lines and routed to one of three paths: the command decoder, the address collector or the page-buffer load port.

The sequencer tracks multi-cycle operations:
- Page read takes a command and then three address bytes.
- Page program takes a command, three address bytes, data bytes and a confirm command.
- Block erase takes a setup command, two row bytes and a confirm command.
- Identification takes a command and then one zero address byte.

When an operation is complete, the sequencer pulses a start strobe toward the array engine and holds the assembled 22-bit address. The engine reports back through `core_busy` and `core_erase`. While the engine is busy, the sequencer accepts only status, reset and erase-suspend commands. An output-select field tells the read path whether to drive array data, status, identification bytes or register contents.

Top module: `nand_cmd_seq`

## Requirements
- R1: A byte is taken only on a cycle with `wr_stb` high and `ce_n` low. With `cle` high it is a command, whether or not `ale` is high. With `cle` low and `ale` high it is an address byte. With both low it is a data byte.
- R2: Command 00h followed by three address bytes loads `addr[7:0]`, `addr[15:8]` and `addr[21:16]` (the last from `io_in[5:0]`), in that order. The third address byte pulses `rd_start` for one cycle and sets `out_sel` to 00 (array data).
- R3: After command 80h and three address bytes, each data byte pulses `ld_stb`, with `ld_data` equal to the byte. `ld_col` starts at the first address byte and increases by one per data byte. A following 10h pulses `prog_start`.
- R4: A 10h that arrives before any data byte of the current program sequence starts nothing and ends the sequence, so later data bytes are not loaded.
- R5: Command 60h, two row bytes and D0h pulse `erase_start`. At that point `addr[12:0]` is zero, `addr[15:13]` comes from bits 7:5 of the first row byte and `addr[21:16]` comes from bits 5:0 of the second.
- R6: With `wp_n` low when the confirm command arrives, neither `prog_start` nor `erase_start` pulses, and the sequence ends.
- R7: While `core_busy` is high, every command except 70h, FFh and B0h is ignored, and so are all address and data bytes. B0h pulses `susp_req` only when `core_erase` is also high.
- R8: Command 70h sets `out_sel` to 01 (status).
- R9: Command 90h followed by address byte 00h sets `out_sel` to 10 (ID) with `id_byte` = ECh. After one `rd_stb` in ID mode, `id_byte` = E3h, and it stays E3h on further reads. A non-zero address byte after 90h leaves `out_sel` unchanged.
- R10: Command E0h sets `out_sel` to 11 (register read).
- R11: Reset (either `rst_n` low or command FFh) clears `addr` to zero, sets `out_sel` to 00 and ends any sequence. Command FFh also pulses `reset_req` so that the page buffer refills with ones.
- R12: A command that arrives in the middle of a sequence drops that sequence and is decoded as a new command. Unknown codes, including 10h and D0h outside their sequences, only drop the pending sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Write-enable rising edge, one cycle |
| rd_stb | input | 1 | Read-enable strobe, one cycle |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| io_in | input | 8 | Bus byte |
| wp_n | input | 1 | Write protect, active low |
| core_busy | input | 1 | Array engine busy |
| core_erase | input | 1 | Busy operation is an erase |
| rd_start | output | 1 | Page read start pulse |
| prog_start | output | 1 | Page program start pulse |
| erase_start | output | 1 | Block erase start pulse |
| susp_req | output | 1 | Erase suspend pulse |
| reset_req | output | 1 | Reset pulse |
| ld_stb | output | 1 | Page buffer write pulse |
| ld_col | output | 10 | Page buffer column |
| ld_data | output | 8 | Page buffer byte |
| addr | output | 22 | Latched address |
| out_sel | output | 2 | Read path select: 00 data, 01 status, 10 ID, 11 register |
| id_byte | output | 8 | Identification byte |

## Verification
The bound checker watches every cycle for rules that hold whatever the sequence:
- Each strobe follows an accepted bus write.
- Loads follow data-class bytes.
- Starts never follow a busy cycle or a protected confirm.
- A suspend follows only a busy erase.
- An erase address is block-aligned.
- Reset leaves a zero address.

Some behaviours are visible only through ordered sequences, so only the bench scenarios show them:
- Correct byte order in the address.
- Column auto-increment.
- Dropping of a program without data.
- Mid-sequence command replacement.
- The two-step ID read.

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq #(
  parameter int AW = 22,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic          rd_stb,
  input  logic          ce_n,
  input  logic          cle,
  input  logic          ale,
  input  logic [7:0]    io_in,
  input  logic          wp_n,
  input  logic          core_busy,
  input  logic          core_erase,
  output logic          rd_start,
  output logic          prog_start,
  output logic          erase_start,
  output logic          susp_req,
  output logic          reset_req,
  output logic          ld_stb,
  output logic [CW-1:0] ld_col,
  output logic [7:0]    ld_data,
  output logic [AW-1:0] addr,
  output logic [1:0]    out_sel,
  output logic [7:0]    id_byte
);
  localparam int HW = AW - 16;
  localparam logic [7:0] C_READ = 8'h00, C_LOAD = 8'h80, C_PROG = 8'h10,
                         C_ESET = 8'h60, C_ECNF = 8'hD0, C_STAT = 8'h70,
                         C_ID   = 8'h90, C_REG  = 8'hE0, C_SUSP = 8'hB0,
                         C_RST  = 8'hFF;
  localparam logic [1:0] OS_DATA = 2'd0, OS_STAT = 2'd1, OS_ID = 2'd2, OS_REG = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_RADR, S_PADR, S_PDAT, S_EADR, S_ECNF, S_IDAD} st_t;

  st_t          st;
  logic [1:0]   acnt;
  logic [CW-1:0] col;
  logic         have;
  logic         id_ptr;

  wire take  = wr_stb & ~ce_n;
  wire cmd_w = take & cle;
  wire adr_w = take & ~cle & ale;
  wire dat_w = take & ~cle & ~ale;

  assign id_byte = id_ptr ? 8'hE3 : 8'hEC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; acnt <= '0; addr <= '0; col <= '0; have <= 1'b0;
      out_sel <= OS_DATA; id_ptr <= 1'b0;
      rd_start <= 1'b0; prog_start <= 1'b0; erase_start <= 1'b0;
      susp_req <= 1'b0; reset_req <= 1'b0; ld_stb <= 1'b0;
      ld_col <= '0; ld_data <= '0;
    end else begin
      rd_start <= 1'b0; prog_start <= 1'b0; erase_start <= 1'b0;
      susp_req <= 1'b0; reset_req <= 1'b0; ld_stb <= 1'b0;
      if (rd_stb && out_sel == OS_ID) id_ptr <= 1'b1;

      if (cmd_w) begin
        if (io_in == C_RST) begin
          st <= S_IDLE; acnt <= '0; addr <= '0; have <= 1'b0;
          out_sel <= OS_DATA; id_ptr <= 1'b0; reset_req <= 1'b1;
        end else if (core_busy) begin
          if (io_in == C_STAT) out_sel <= OS_STAT;
          if (io_in == C_SUSP && core_erase) susp_req <= 1'b1;
        end else begin
          acnt <= '0;
          case (io_in)
            C_READ: st <= S_RADR;
            C_LOAD: begin st <= S_PADR; have <= 1'b0; end
            C_ESET: st <= S_EADR;
            C_ID:   st <= S_IDAD;
            C_PROG: begin
              if (st == S_PDAT && have && wp_n) prog_start <= 1'b1;
              st <= S_IDLE;
            end
            C_ECNF: begin
              if (st == S_ECNF && wp_n) erase_start <= 1'b1;
              st <= S_IDLE;
            end
            C_STAT: begin out_sel <= OS_STAT; st <= S_IDLE; end
            C_REG:  begin out_sel <= OS_REG;  st <= S_IDLE; end
            default: st <= S_IDLE;
          endcase
        end
      end else if (adr_w && !core_busy) begin
        case (st)
          S_RADR, S_PADR: begin
            acnt <= acnt + 2'd1;
            case (acnt)
              2'd0: addr[7:0]   <= io_in;
              2'd1: addr[15:8]  <= io_in;
              default: begin
                addr[AW-1:16] <= io_in[HW-1:0];
                if (st == S_RADR) begin
                  rd_start <= 1'b1; out_sel <= OS_DATA; st <= S_IDLE;
                end else begin
                  col <= CW'(addr[7:0]); st <= S_PDAT;
                end
              end
            endcase
          end
          S_EADR: begin
            acnt <= acnt + 2'd1;
            if (acnt == 2'd0) begin
              addr[12:0]  <= '0;
              addr[15:13] <= io_in[7:5];
            end else begin
              addr[AW-1:16] <= io_in[HW-1:0];
              st <= S_ECNF;
            end
          end
          S_IDAD: begin
            if (io_in == 8'h00) begin out_sel <= OS_ID; id_ptr <= 1'b0; end
            st <= S_IDLE;
          end
          default: ;
        endcase
      end else if (dat_w && !core_busy && st == S_PDAT) begin
        ld_stb <= 1'b1; ld_data <= io_in; ld_col <= col;
        col <= col + 1'b1; have <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk #(
  parameter int AW = 22,
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_stb,
  input logic          rd_stb,
  input logic          ce_n,
  input logic          cle,
  input logic          ale,
  input logic          wp_n,
  input logic          core_busy,
  input logic          core_erase,
  input logic          rd_start,
  input logic          prog_start,
  input logic          erase_start,
  input logic          susp_req,
  input logic          reset_req,
  input logic          ld_stb,
  input logic [AW-1:0] addr,
  input logic [1:0]    out_sel,
  input logic [7:0]    id_byte
);
  // R1
  strobe_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start | prog_start | erase_start | susp_req | reset_req | ld_stb) |-> $past(wr_stb && !ce_n));
  // R1
  load_is_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb |-> $past(!cle && !ale));
  // R6
  start_unprotected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_start | erase_start) |-> $past(wp_n));
  // R7
  start_idle_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start | prog_start | erase_start | ld_stb) |-> $past(!core_busy));
  // R7
  susp_in_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    susp_req |-> $past(core_busy && core_erase));
  // R5
  erase_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> (addr[12:0] == 13'd0));
  // R11
  reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (addr == '0 && out_sel == 2'd0));
  // R9
  id_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sel == 2'd2 && $past(out_sel == 2'd2) && $past(rd_stb)) |-> (id_byte == 8'hE3));
endmodule

bind nand_cmd_seq nand_cmd_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb), .ce_n(ce_n),
  .cle(cle), .ale(ale), .wp_n(wp_n), .core_busy(core_busy), .core_erase(core_erase),
  .rd_start(rd_start), .prog_start(prog_start), .erase_start(erase_start),
  .susp_req(susp_req), .reset_req(reset_req), .ld_stb(ld_stb), .addr(addr),
  .out_sel(out_sel), .id_byte(id_byte)
);

// File: tb/nand_cmd_seq_test.sv
module nand_cmd_seq_test;
  logic clk = 0, rst_n = 0, wr_stb = 0, rd_stb = 0, ce_n = 0, cle = 0, ale = 0;
  logic [7:0] io_in = 0;
  logic wp_n = 1, core_busy = 0, core_erase = 0;
  logic rd_start, prog_start, erase_start, susp_req, reset_req, ld_stb;
  logic [9:0] ld_col;
  logic [7:0] ld_data, id_byte;
  logic [21:0] addr;
  logic [1:0] out_sel;

  int compared = 0, mismatched = 0;
  bit done = 0;

  typedef struct { int kind; logic [31:0] pay; string req; } ev_t;
  ev_t expq[$];

  always #2 clk = ~clk;

  nand_cmd_seq uut (.*);

  task automatic expect_ev(int kind, logic [31:0] pay, string req);
    ev_t e; e.kind = kind; e.pay = pay; e.req = req; expq.push_back(e);
  endtask

  task automatic put(logic c, logic a, logic [7:0] b);
    @(negedge clk); wr_stb = 1; cle = c; ale = a; io_in = b;
    @(negedge clk); wr_stb = 0; cle = 0; ale = 0;
  endtask
  task automatic cmd(logic [7:0] b); put(1, 0, b); endtask
  task automatic adr(logic [7:0] b); put(0, 1, b); endtask
  task automatic dat(logic [7:0] b); put(0, 0, b); endtask
  task automatic rpulse();
    @(negedge clk); rd_stb = 1; @(negedge clk); rd_stb = 0;
  endtask

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    int k; logic [31:0] p; ev_t e;
    k = 0; p = 0;
    if (rd_start)         begin k = 1; p = 32'(addr); end
    else if (prog_start)  begin k = 2; p = 32'(addr); end
    else if (erase_start) begin k = 3; p = 32'(addr); end
    else if (ld_stb)      begin k = 4; p = {14'd0, ld_col, ld_data}; end
    else if (susp_req)    k = 5;
    else if (reset_req)   k = 6;
    if (k != 0) begin
      compared++;
      if (expq.size() == 0) begin
        mismatched++;
        $display("FAIL unexpected event: got kind %0d payload %h expected none", k, p);
      end else begin
        e = expq.pop_front();
        if (e.kind != k || e.pay !== p) begin
          mismatched++;
          $display("FAIL %s: got kind %0d payload %h expected kind %0d payload %h",
                   e.req, k, p, e.kind, e.pay);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check("R11", 32'(addr), 0);
    check("R11", 32'(out_sel), 0);
    check("R9", 32'(id_byte), 32'hEC);

    // R2 page read
    expect_ev(1, 32'h2A3412, "R2");
    cmd(8'h00); adr(8'h12); adr(8'h34); adr(8'h2A);
    check("R2", 32'(addr), 32'h2A3412);
    check("R2", 32'(out_sel), 0);

    // R1 deselected write ignored; CLE wins over ALE
    @(negedge clk); ce_n = 1; cmd(8'h70); ce_n = 0;
    check("R1", 32'(out_sel), 0);
    put(1, 1, 8'hE0);
    check("R1", 32'(out_sel), 3);

    // R3 program with column increment
    expect_ev(4, {14'd0, 10'd5, 8'hAA}, "R3");
    expect_ev(4, {14'd0, 10'd6, 8'hBB}, "R3");
    expect_ev(2, 32'h010205, "R3");
    cmd(8'h80); adr(8'h05); adr(8'h02); adr(8'h01);
    dat(8'hAA); dat(8'hBB); cmd(8'h10);

    // R4 confirm without data
    cmd(8'h80); adr(8'h01); adr(8'h00); adr(8'h00);
    cmd(8'h10); dat(8'h55);

    // R6 protected program
    expect_ev(4, {14'd0, 10'd3, 8'h11}, "R6");
    cmd(8'h80); adr(8'h03); adr(8'h00); adr(8'h00); dat(8'h11);
    wp_n = 0; cmd(8'h10); wp_n = 1; dat(8'h22);

    // R5 block erase
    expect_ev(3, 32'h01E000, "R5");
    cmd(8'h60); adr(8'hFF); adr(8'h01); cmd(8'hD0);
    check("R5", 32'(addr), 32'h01E000);

    // R6 protected erase
    cmd(8'h60); adr(8'h20); adr(8'h02); wp_n = 0; cmd(8'hD0); wp_n = 1;

    // R12 mid-sequence replacement
    expect_ev(1, 32'h030201, "R12");
    cmd(8'h60); adr(8'h40); cmd(8'h00); adr(8'h01); adr(8'h02); adr(8'h03);
    cmd(8'h80); adr(8'h01); cmd(8'h70);
    check("R8", 32'(out_sel), 1);
    adr(8'h09); dat(8'h09); cmd(8'hD0);
    check("R12", 32'(addr), 32'h030201);

    // R10 register read, R9 ID
    cmd(8'hE0);
    check("R10", 32'(out_sel), 3);
    cmd(8'h90); adr(8'h01);
    check("R9", 32'(out_sel), 3);
    cmd(8'h90); adr(8'h00);
    check("R9", 32'(out_sel), 2);
    check("R9", 32'(id_byte), 32'hEC);
    rpulse();
    check("R9", 32'(id_byte), 32'hE3);
    rpulse();
    check("R9", 32'(id_byte), 32'hE3);

    // R7 busy filtering
    @(negedge clk); core_busy = 1; core_erase = 0;
    cmd(8'h00); adr(8'h07); adr(8'h07); adr(8'h07);
    cmd(8'h80); dat(8'h33); cmd(8'hB0); cmd(8'hE0);
    check("R7", 32'(out_sel), 2);
    expect_ev(5, 0, "R7");
    core_erase = 1; cmd(8'hB0);
    cmd(8'h70);
    check("R8", 32'(out_sel), 1);
    expect_ev(6, 0, "R11");
    cmd(8'hFF);
    check("R11", 32'(addr), 0);
    check("R11", 32'(out_sel), 0);
    @(negedge clk); core_busy = 0; core_erase = 0;

    // R11 reset while idle after address load
    expect_ev(1, 32'h000077, "R2");
    cmd(8'h00); adr(8'h77); adr(8'h00); adr(8'h00);
    expect_ev(6, 0, "R11");
    cmd(8'hFF);
    check("R11", 32'(addr), 0);

    repeat (4) @(negedge clk);
    compared++;
    if (expq.size() != 0) begin
      mismatched++;
      $display("FAIL %s: got %0d events missing expected 0", expq[0].req, expq.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule